// File: doc/BRIEF.md
# Stack-Addressed Register File with Zero-Cycle Exchange

This block is an eight-entry register file for floating-point operands. It is addressed relative to a moving top-of-stack pointer, not by absolute slot number. Index 0 always names the current top, and index i names the entry i places below it. Each cycle the block takes one command: push, pop, exchange, operate or indexed write. Two combinational read ports always present the top entry and the entry selected by the command index. These are the operands of a two-operand operation, whose result replaces the top.

The arithmetic unit sits outside the block. A separate write-back port returns a result value together with its destination index. An exchange swaps the top with any other entry by swapping two entries of a small logical-to-physical slot map. The 80-bit data stays where it is, and the swap is visible to the command issued in the very next cycle. Each physical slot carries a valid tag. Pushing onto a full stack is refused and reported as overflow. Touching an empty entry is refused and reported as underflow.

Top module: `stk_regfile`

## Requirements
- R1: After reset the stack is empty. `top_valid` and `idx_valid` are 0 for every index, and `ovf` and `unf` are 0.
- R2: A push (cmd_op 1) on a stack with fewer than 8 entries makes `cmd_data` the new index 0. Every older entry moves to an index one greater.
- R3: A push onto a stack that holds 8 entries changes nothing. `ovf` reads 1 in the following cycle.
- R4: A pop (cmd_op 2) on a non-empty stack removes index 0. The entry that was at index i becomes index i-1.
- R5: Pop on an empty stack, or exchange, operate or write naming an empty index, changes nothing. `unf` reads 1 in the following cycle.
- R6: `top_data`/`top_valid` show index 0, and `idx_data`/`idx_valid` show index `cmd_idx`. Both ports are combinational from the current state.
- R7: An exchange (cmd_op 3) swaps the contents of index 0 and index `cmd_idx`, and the next cycle's reads see the swap. Index 0 leaves the stack unchanged.
- R8: An indexed write (cmd_op 5) to a held index replaces that entry with `cmd_data`.
- R9: With `wb_en` high, `wb_data` replaces the held entry at `wb_idx`. The index is resolved against the stack as it was before any command in the same cycle. A write-back to an empty index changes nothing and sets `unf` in the following cycle.
- R10: When an indexed write and a write-back hit the same entry in one cycle, the indexed write's data is kept.
- R11: `ovf` and `unf` are registered single-cycle reports. Each falls back to 0 after a cycle without a new fault.
- R12: An operate command (cmd_op 4) changes no state. It reports underflow if index 0 or index `cmd_idx` is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 push, 2 pop, 3 exchange, 4 operate, 5 write; 6 and 7 act as none |
| cmd_idx | input | 3 | Relative index for read port B, exchange, operate and write |
| cmd_data | input | 80 | Value for push and indexed write |
| wb_en | input | 1 | Write-back strobe |
| wb_idx | input | 3 | Relative destination index of the write-back |
| wb_data | input | 80 | Write-back result value |
| top_data | output | 80 | Contents of index 0 |
| top_valid | output | 1 | Index 0 holds a value |
| idx_data | output | 80 | Contents of index `cmd_idx` |
| idx_valid | output | 1 | Index `cmd_idx` holds a value |
| ovf | output | 1 | Overflow report for the previous cycle |
| unf | output | 1 | Underflow report for the previous cycle |

## Verification
The push, pop and exchange properties assume that no write-back arrives in the same cycle. A write-back could rewrite the entry they compare, so each property's antecedent requires `wb_en` low. The pop property also assumes `cmd_idx` is 1 during the pop, so that the read port already shows the entry that becomes the new top. The stimulus meets this by leaving `cmd_idx` at 1 on pops in the directed phases, and the properties simply do not engage on the other cycles. The directed phases and the pseudo-random mix together reach every index for every command on a full and an empty stack, as well as write-back collisions with indexed writes.

// File: rtl/stkrf_pkg.sv
package stkrf_pkg;

    localparam int STK_IDXW  = 3;
    localparam int STK_DEPTH = 1 << STK_IDXW;
    localparam int STK_WIDTH = 80;

    typedef logic [STK_IDXW-1:0] slot_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_XCHG  = 3'd3,
        OP_OPER  = 3'd4,
        OP_WRITE = 3'd5
    } stk_op_e;

    // Control decisions taken for one cycle.
    typedef struct packed {
        logic  cwr_en;    // command write (push / indexed write)
        slot_t cwr_slot;
        logic  bwr_en;    // write-back write
        slot_t bwr_slot;
        logic  clr_en;    // pop frees a slot
        slot_t clr_slot;
        logic  ptr_inc;
        logic  ptr_dec;
        logic  swap_en;   // exchange: swap two map positions
        slot_t swap_a;
        slot_t swap_b;
        logic  ovf;
        logic  unf;
    } stk_ctl_t;

    // Map position of a relative index, wrapping modulo depth.
    function automatic slot_t rel_pos(slot_t top, slot_t off);
        slot_t r;
        r = top + off;
        return r;
    endfunction

endpackage

// File: rtl/stkrf_ptr.sv
module stkrf_ptr
    import stkrf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inc,
    input  logic  dec,
    output slot_t top_o
);
    slot_t top_q;

    always_ff @(posedge clk) begin
        if (rst)
            top_q <= '0;
        else if (inc)
            top_q <= top_q + slot_t'(1);
        else if (dec)
            top_q <= top_q - slot_t'(1);
    end

    assign top_o = top_q;
endmodule

// File: rtl/stkrf_map.sv
module stkrf_map
    import stkrf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  swap_en,
    input  slot_t                 swap_a,
    input  slot_t                 swap_b,
    output slot_t [STK_DEPTH-1:0] map_o
);
    slot_t [STK_DEPTH-1:0] map_q;

    for (genvar p = 0; p < STK_DEPTH; p++) begin : g_pos
        localparam slot_t POS = slot_t'(p);
        always_ff @(posedge clk) begin
            if (rst)
                map_q[p] <= POS;
            else if (swap_en && swap_a == POS)
                map_q[p] <= map_q[swap_b];
            else if (swap_en && swap_b == POS)
                map_q[p] <= map_q[swap_a];
        end
    end

    assign map_o = map_q;
endmodule

// File: rtl/stkrf_store.sv
module stkrf_store
    import stkrf_pkg::*;
#(
    parameter int WIDTH = STK_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cwr_en,
    input  slot_t                cwr_slot,
    input  logic [WIDTH-1:0]     cwr_data,
    input  logic                 bwr_en,
    input  slot_t                bwr_slot,
    input  logic [WIDTH-1:0]     bwr_data,
    input  logic                 clr_en,
    input  slot_t                clr_slot,
    input  slot_t                rd_a_slot,
    input  slot_t                rd_b_slot,
    output logic [WIDTH-1:0]     rd_a_data,
    output logic [WIDTH-1:0]     rd_b_data,
    output logic [STK_DEPTH-1:0] valid_o
);
    logic [WIDTH-1:0]     data_q [STK_DEPTH];
    logic [STK_DEPTH-1:0] valid_q;

    for (genvar s = 0; s < STK_DEPTH; s++) begin : g_slot
        localparam slot_t SLOT = slot_t'(s);
        logic c_hit, b_hit, k_hit;
        assign c_hit = cwr_en && (cwr_slot == SLOT);
        assign b_hit = bwr_en && (bwr_slot == SLOT);
        assign k_hit = clr_en && (clr_slot == SLOT);

        // Command data has priority over write-back on the same slot.
        always_ff @(posedge clk) begin
            if (rst)
                data_q[s] <= '0;
            else if (c_hit)
                data_q[s] <= cwr_data;
            else if (b_hit)
                data_q[s] <= bwr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                valid_q[s] <= 1'b0;
            else if (c_hit)
                valid_q[s] <= 1'b1;
            else if (k_hit)
                valid_q[s] <= 1'b0;
        end
    end

    assign rd_a_data = data_q[rd_a_slot];
    assign rd_b_data = data_q[rd_b_slot];
    assign valid_o   = valid_q;
endmodule

// File: rtl/stkrf_ctrl.sv
module stkrf_ctrl
    import stkrf_pkg::*;
(
    input  logic [2:0]            cmd_op,
    input  slot_t                 cmd_idx,
    input  logic                  wb_en,
    input  slot_t                 wb_idx,
    input  slot_t                 top,
    input  slot_t [STK_DEPTH-1:0] map,
    input  logic [STK_DEPTH-1:0]  valid,
    output slot_t                 phys_top,
    output slot_t                 phys_idx,
    output stk_ctl_t              ctl
);
    slot_t   pos_idx, pos_new, pos_wb;
    slot_t   phys_new, phys_wb;
    logic    v_top, v_idx, v_new, v_wb;
    stk_op_e op;

    always_comb begin
        pos_idx  = rel_pos(top, cmd_idx);
        pos_new  = top - slot_t'(1);
        pos_wb   = rel_pos(top, wb_idx);
        phys_top = map[top];
        phys_idx = map[pos_idx];
        phys_new = map[pos_new];
        phys_wb  = map[pos_wb];
        v_top    = valid[phys_top];
        v_idx    = valid[phys_idx];
        v_new    = valid[phys_new];
        v_wb     = valid[phys_wb];
        op       = stk_op_e'(cmd_op);
    end

    always_comb begin
        ctl = '0;
        if (wb_en) begin
            if (v_wb) begin
                ctl.bwr_en   = 1'b1;
                ctl.bwr_slot = phys_wb;
            end else begin
                ctl.unf = 1'b1;
            end
        end
        case (op)
            OP_PUSH: begin
                if (v_new) begin
                    ctl.ovf = 1'b1;
                end else begin
                    ctl.cwr_en   = 1'b1;
                    ctl.cwr_slot = phys_new;
                    ctl.ptr_dec  = 1'b1;
                end
            end
            OP_POP: begin
                if (!v_top) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.clr_en   = 1'b1;
                    ctl.clr_slot = phys_top;
                    ctl.ptr_inc  = 1'b1;
                end
            end
            OP_XCHG: begin
                if (!(v_top && v_idx)) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.swap_en = 1'b1;
                    ctl.swap_a  = top;
                    ctl.swap_b  = pos_idx;
                end
            end
            OP_OPER: begin
                if (!(v_top && v_idx))
                    ctl.unf = 1'b1;
            end
            OP_WRITE: begin
                if (!v_idx) begin
                    ctl.unf = 1'b1;
                end else begin
                    ctl.cwr_en   = 1'b1;
                    ctl.cwr_slot = phys_idx;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile
    import stkrf_pkg::*;
#(
    parameter int WIDTH = STK_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cmd_op,
    input  logic [2:0]       cmd_idx,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic             wb_en,
    input  logic [2:0]       wb_idx,
    input  logic [WIDTH-1:0] wb_data,
    output logic [WIDTH-1:0] top_data,
    output logic             top_valid,
    output logic [WIDTH-1:0] idx_data,
    output logic             idx_valid,
    output logic             ovf,
    output logic             unf
);
    slot_t                 top;
    slot_t [STK_DEPTH-1:0] map;
    logic [STK_DEPTH-1:0]  valid;
    slot_t                 phys_top, phys_idx;
    stk_ctl_t              ctl;
    logic                  ovf_q, unf_q;

    stkrf_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .inc   (ctl.ptr_inc),
        .dec   (ctl.ptr_dec),
        .top_o (top)
    );

    stkrf_map u_map (
        .clk     (clk),
        .rst     (rst),
        .swap_en (ctl.swap_en),
        .swap_a  (ctl.swap_a),
        .swap_b  (ctl.swap_b),
        .map_o   (map)
    );

    stkrf_ctrl u_ctrl (
        .cmd_op   (cmd_op),
        .cmd_idx  (cmd_idx),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .top      (top),
        .map      (map),
        .valid    (valid),
        .phys_top (phys_top),
        .phys_idx (phys_idx),
        .ctl      (ctl)
    );

    stkrf_store #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cwr_en    (ctl.cwr_en),
        .cwr_slot  (ctl.cwr_slot),
        .cwr_data  (cmd_data),
        .bwr_en    (ctl.bwr_en),
        .bwr_slot  (ctl.bwr_slot),
        .bwr_data  (wb_data),
        .clr_en    (ctl.clr_en),
        .clr_slot  (ctl.clr_slot),
        .rd_a_slot (phys_top),
        .rd_b_slot (phys_idx),
        .rd_a_data (top_data),
        .rd_b_data (idx_data),
        .valid_o   (valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ctl.ovf;
            unf_q <= ctl.unf;
        end
    end

    assign top_valid = valid[phys_top];
    assign idx_valid = valid[phys_idx];
    assign ovf       = ovf_q;
    assign unf       = unf_q;
endmodule

// File: rtl/stkrf_chk.sv
module stkrf_chk #(
    parameter int WIDTH = 80
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd_op,
    input logic [2:0]       cmd_idx,
    input logic [WIDTH-1:0] cmd_data,
    input logic             wb_en,
    input logic [WIDTH-1:0] top_data,
    input logic             top_valid,
    input logic [WIDTH-1:0] idx_data,
    input logic             idx_valid,
    input logic             ovf,
    input logic             unf
);
    // R2 and R3: a push either lands on top or is refused with top untouched.
    assert_push_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd1 && !wb_en) |=>
        (ovf ? (top_data == $past(top_data))
             : (top_valid && top_data == $past(cmd_data))));

    assert_ovf_only_push_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |-> ($past(cmd_op) == 3'd1));

    assert_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd2 && cmd_idx == 3'd1 && !wb_en) |=>
        (unf || (top_valid == $past(idx_valid) &&
                 (!top_valid || top_data == $past(idx_data)))));

    assert_unf_source_R5: assert property (@(posedge clk) disable iff (rst)
        unf |-> ($past(wb_en) || $past(cmd_op) == 3'd2 || $past(cmd_op) == 3'd3 ||
                 $past(cmd_op) == 3'd4 || $past(cmd_op) == 3'd5));

    assert_xchg_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd3 && !wb_en) |=>
        (unf || (top_valid && top_data == $past(idx_data))));

    assert_reset_empty_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!top_valid && !idx_valid && !ovf && !unf));
endmodule

bind stk_regfile stkrf_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .wb_en     (wb_en),
    .top_data  (top_data),
    .top_valid (top_valid),
    .idx_data  (idx_data),
    .idx_valid (idx_valid),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/stk_regfile_tb.sv
`timescale 1ns/1ps
module stk_regfile_tb;
    localparam int W = 80;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   cmd_op = '0;
    logic [2:0]   cmd_idx = '0;
    logic [W-1:0] cmd_data = '0;
    logic         wb_en = 1'b0;
    logic [2:0]   wb_idx = '0;
    logic [W-1:0] wb_data = '0;
    logic [W-1:0] top_data, idx_data;
    logic         top_valid, idx_valid, ovf, unf;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m [8];
    int depth = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    stk_regfile u_dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .top_data(top_data), .top_valid(top_valid), .idx_data(idx_data),
        .idx_valid(idx_valid), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input int k);
        return {16'hC3A5, 32'(k * 7 + 3), 32'(k) ^ 32'h5A5A_0F0F};
    endfunction

    // Called at a falling edge: drives one cycle, checks reads, then flags.
    task automatic apply(input logic [2:0] op, input int idx, input logic [W-1:0] d,
                         input logic we, input int wi, input logic [W-1:0] wd);
        logic eo, eu;
        logic [W-1:0] t;
        cmd_op = op; cmd_idx = 3'(idx); cmd_data = d;
        wb_en = we; wb_idx = 3'(wi); wb_data = wd;
        #1;
        chk(W'(top_valid), W'(depth > 0), "R6 top_valid");
        if (depth > 0) chk(top_data, m[0], "R2 R4 R7 top_data");
        chk(W'(idx_valid), W'(idx < depth), "R6 idx_valid");
        if (idx < depth) chk(idx_data, m[idx], "R6 R8 R9 idx_data");
        eo = 1'b0; eu = 1'b0;
        if (we) begin
            if (wi < depth) m[wi] = wd; else eu = 1'b1;   // R9
        end
        case (op)
            3'd1: if (depth == 8) eo = 1'b1;
                  else begin
                      for (int i = 7; i > 0; i--) m[i] = m[i-1];
                      m[0] = d; depth++;
                  end
            3'd2: if (depth == 0) eu = 1'b1;
                  else begin
                      for (int i = 0; i < 7; i++) m[i] = m[i+1];
                      depth--;
                  end
            3'd3: if (idx >= depth) eu = 1'b1;
                  else begin t = m[0]; m[0] = m[idx]; m[idx] = t; end
            3'd4: if (idx >= depth) eu = 1'b1;                 // R12
            3'd5: if (idx >= depth) eu = 1'b1; else m[idx] = d; // R8, R10
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk(W'(ovf), W'(eo), "R3 R11 ovf");
        chk(W'(unf), W'(eu), "R5 R11 unf");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset at every index.
        for (int i = 0; i < 8; i++) begin
            cmd_idx = 3'(i);
            #1;
            chk(W'(idx_valid), '0, "R1 idx_valid");
            chk(W'(top_valid), '0, "R1 top_valid");
            chk(W'(ovf), '0, "R1 ovf");
            chk(W'(unf), '0, "R1 unf");
        end
        // R2: fill; R3: overflow on the ninth.
        for (int k = 0; k < 8; k++) apply(3'd1, 1, mk(k), 1'b0, 0, '0);
        apply(3'd1, 7, mk(99), 1'b0, 0, '0);
        apply(3'd0, 7, '0, 1'b0, 0, '0);
        // R6, R12: operate at every index.
        for (int i = 0; i < 8; i++) apply(3'd4, i, '0, 1'b0, 0, '0);
        // R7: exchange sweep, each followed by a read.
        for (int i = 0; i < 8; i++) begin
            apply(3'd3, i, '0, 1'b0, 0, '0);
            apply(3'd0, i, '0, 1'b0, 0, '0);
        end
        // R8: indexed write everywhere.
        for (int i = 0; i < 8; i++) apply(3'd5, i, mk(20 + i), 1'b0, 0, '0);
        // R9: write-back everywhere; R10: collision with indexed write.
        for (int i = 0; i < 8; i++) apply(3'd0, i, '0, 1'b1, i, mk(40 + i));
        for (int i = 0; i < 8; i++) apply(3'd5, i, mk(60 + i), 1'b1, i, mk(80 + i));
        for (int i = 0; i < 8; i++) apply(3'd0, i, '0, 1'b0, 0, '0);
        // R4: drain; R5: underflow on the extra pop.
        for (int k = 0; k < 9; k++) apply(3'd2, 1, '0, 1'b0, 0, '0);
        // R5, R9: every faulting access on an empty stack.
        apply(3'd3, 2, '0, 1'b0, 0, '0);
        apply(3'd4, 0, '0, 1'b0, 0, '0);
        apply(3'd5, 3, mk(5), 1'b0, 0, '0);
        apply(3'd0, 0, '0, 1'b1, 0, mk(6));
        apply(3'd0, 0, '0, 1'b0, 0, '0);
        // Mixed pseudo-random traffic, write-back included.
        for (int s = 0; s < 4000; s++) begin
            logic [2:0] op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = (lfsr[2:0] > 3'd5) ? 3'd1 : lfsr[2:0];
            apply(op, int'(lfsr[5:3]), mk(s + 200), lfsr[9] & lfsr[8],
                  int'(lfsr[12:10]), mk(s + 9000));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule